// File: doc/BRIEF.md
# Receive Byte Queue with Trigger Level and Idle Timeout

This block buffers received bytes for a serial controller. A deserializer hands it one byte per strobe. Software drains the bytes through a read strobe that pops the oldest entry. The queue holds sixteen bytes and reports how many it holds.

A data-ready flag tells software when to come and read. The flag rises when a push brings the fill level up to a programmable threshold. The threshold is picked from four fixed values by a 2-bit select. When fewer bytes than the threshold have arrived and the line then goes quiet, an idle timer raises the flag after fifteen character times. The character-time tick comes from outside the block.

The same events raise a receive interrupt, but only while the interrupt enable is high. Dropping the enable withdraws the interrupt. Reads do not withdraw it.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset, `level` is 0, `data_full` and `rx_irq` are 0, and `rd_data` reads 0x00.
- R2: Bytes leave in the order they arrived. `rd_data` shows the oldest byte before it is popped, and storage indices wrap past entry 15 with no loss of order.
- R3: A byte strobed in while 16 entries are held is dropped. The count stays 16 and the stored bytes are unchanged.
- R4: While `rx_en` is low, byte strobes are ignored and the count does not change.
- R5: `trig_sel` values 0, 1, 2 and 3 select trigger levels of 1, 4, 8 and 14 entries. A push that leaves the count at or above the level sets `data_full` at that clock edge.
- R6: A push that reaches the trigger level with `rie` high asserts `rx_irq`. While `rie` is low, `rx_irq` is 0 from the next clock edge on.
- R7: A push that leaves the count below the trigger level restarts the idle timer. After 15 `char_tick` cycles with no further push, `data_full` is set, and `rx_irq` is also set if `rie` is high.
- R8: A pop removes the oldest byte and decrements the count. If the new count is below the trigger level, `data_full` clears.
- R9: A pop of an empty queue gives `rd_data` 0x00 and changes neither the count nor the flags.
- R10: `fifo_clr` empties the queue at the next edge and overrides any push or pop in the same cycle. The next byte stored is the next one read.
- R11: A push and a pop in the same cycle on a queue that is neither empty nor full leave the count unchanged and keep the order.
- R12: A push that reaches the trigger level with `rie` high stops the idle timer. Later ticks then do not raise `data_full` again after pops have cleared it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Received byte strobe |
| byte_in | input | 8 | Received byte |
| rd_pop | input | 1 | Pop the oldest byte |
| fifo_clr | input | 1 | Empty the queue |
| trig_sel | input | 2 | Trigger level select (0:1, 1:4, 2:8, 3:14) |
| rx_en | input | 1 | Receive enable |
| rie | input | 1 | Receive interrupt enable |
| char_tick | input | 1 | One-cycle pulse per character time |
| rd_data | output | 8 | Oldest byte, 0x00 when empty |
| level | output | 5 | Number of stored bytes |
| data_full | output | 1 | Data-ready flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The hardest state to reach is an idle timer that was stopped by a push at the trigger level. Nothing at the ports shows it directly, because the flag is already high when the timer stops. The stimulus fills the queue to the level with the interrupt enabled, then pops one byte so the flag falls. It then supplies many more ticks than a timeout needs and confirms that the flag stays low. The timer restart is proven the same way: a second push lands partway through a countdown, and the flag stays low past the point where the first countdown would have ended.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int SEL_W = 2;

    typedef struct packed {
        logic push;
        logic pop;
        logic clr;
    } rxq_op_t;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_t;

    function automatic int trig_level(input logic [SEL_W-1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  rxq_op_t           req,
    input  logic [DATA_W-1:0] din,
    output logic              acc_push,
    output logic              acc_pop,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_nxt,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  head_q, tail_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign acc_push = req.push && !req.clr && (cnt_q != CNT_W'(DEPTH));
    assign acc_pop  = req.pop  && !req.clr && (cnt_q != '0);

    always_comb begin
        cnt_nxt = cnt_q;
        if (req.clr)
            cnt_nxt = '0;
        else if (acc_push && !acc_pop)
            cnt_nxt = cnt_q + 1'b1;
        else if (acc_pop && !acc_push)
            cnt_nxt = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || req.clr) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            if (acc_push) head_q <= bump(head_q);
            if (acc_pop)  tail_q <= bump(tail_q);
        end
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (acc_push && head_q == PTR_W'(e))
                mem[e] <= din;
        end
    end

    assign dout = (cnt_q == '0) ? '0 : mem[tail_q];
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer
    import rxq_pkg::*;
#(
    parameter int TMO_CHARS = 15,
    localparam int TW = $clog2(TMO_CHARS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic cancel,
    input  logic tick,
    output logic expire
);
    tmr_state_t st_q;
    logic [TW-1:0] ticks_q;

    assign expire = (st_q == TMR_RUN) && !restart && !cancel && tick
                    && (ticks_q == TW'(TMO_CHARS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= TMR_IDLE;
            ticks_q <= '0;
        end else if (restart) begin
            st_q    <= TMR_RUN;
            ticks_q <= '0;
        end else if (cancel || expire) begin
            st_q    <= TMR_IDLE;
            ticks_q <= '0;
        end else if (st_q == TMR_RUN && tick) begin
            ticks_q <= ticks_q + 1'b1;
        end
    end
endmodule

// File: rtl/rxq_flag.sv
module rxq_flag
    import rxq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_push,
    input  logic             acc_pop,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [SEL_W-1:0] trig_sel,
    input  logic             rie,
    input  logic             expire,
    output logic             restart,
    output logic             cancel,
    output logic             full_q,
    output logic             irq_q
);
    logic at_trig;
    logic full_d, irq_d;

    assign at_trig = int'(cnt_nxt) >= trig_level(trig_sel);
    assign restart = acc_push && !at_trig;
    assign cancel  = acc_push && at_trig && rie;

    always_comb begin
        full_d = full_q;
        if (acc_push && at_trig) full_d = 1'b1;
        if (acc_pop && !at_trig) full_d = 1'b0;
        if (expire)              full_d = 1'b1;
        irq_d = irq_q;
        if (((acc_push && at_trig) || expire) && rie) irq_d = 1'b1;
        if (!rie) irq_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            full_q <= full_d;
            irq_q  <= irq_d;
        end
    end
endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int DATA_W    = 8,
    parameter int TMO_CHARS = 15,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              rd_pop,
    input  logic              fifo_clr,
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic              rx_en,
    input  logic              rie,
    input  logic              char_tick,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  level,
    output logic              data_full,
    output logic              rx_irq
);
    rxq_op_t          op;
    logic             acc_push, acc_pop;
    logic [CNT_W-1:0] cnt_nxt;
    logic             restart, cancel, expire;

    assign op = '{push: byte_vld && rx_en, pop: rd_pop, clr: fifo_clr};

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .req(op), .din(byte_in),
        .acc_push(acc_push), .acc_pop(acc_pop),
        .cnt_q(level), .cnt_nxt(cnt_nxt), .dout(rd_data)
    );

    rxq_flag #(.CNT_W(CNT_W)) u_flag (
        .clk(clk), .rst(rst), .acc_push(acc_push), .acc_pop(acc_pop),
        .cnt_nxt(cnt_nxt), .trig_sel(trig_sel), .rie(rie), .expire(expire),
        .restart(restart), .cancel(cancel), .full_q(data_full), .irq_q(rx_irq)
    );

    rxq_timer #(.TMO_CHARS(TMO_CHARS)) u_timer (
        .clk(clk), .rst(rst), .restart(restart), .cancel(cancel),
        .tick(char_tick), .expire(expire)
    );
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              byte_vld,
    input logic              rx_en,
    input logic              rd_pop,
    input logic              fifo_clr,
    input logic              rie,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  level,
    input logic              rx_irq
);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        level <= CNT_W'(DEPTH));

    p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (level == CNT_W'(DEPTH) && byte_vld && !rd_pop && !fifo_clr) |=> level == CNT_W'(DEPTH));

    p_rx_off_r4: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !rd_pop && !fifo_clr) |=> $stable(level));

    p_empty_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (level == '0) |-> rd_data == '0);

    p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
        (level == '0 && rd_pop && !(byte_vld && rx_en) && !fifo_clr) |=> level == '0);

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> level == '0);

    p_push_pop_r11: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && rx_en && rd_pop && !fifo_clr && level != '0 && level != CNT_W'(DEPTH))
        |=> $stable(level));

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
        !rie |=> !rx_irq);
endmodule

bind rx_trig_fifo rxq_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .rx_en(rx_en), .rd_pop(rd_pop),
    .fifo_clr(fifo_clr), .rie(rie), .rd_data(rd_data), .level(level), .rx_irq(rx_irq)
);

// File: tb/sim_rx_trig_fifo.sv
`timescale 1ns/1ps
module sim_rx_trig_fifo;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       rd_pop = 1'b0;
    logic       fifo_clr = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       rx_en = 1'b1;
    logic       rie = 1'b0;
    logic       char_tick = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] level;
    logic       data_full;
    logic       rx_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rx_trig_fifo u0 (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in),
        .rd_pop(rd_pop), .fifo_clr(fifo_clr), .trig_sel(trig_sel),
        .rx_en(rx_en), .rie(rie), .char_tick(char_tick),
        .rd_data(rd_data), .level(level), .data_full(data_full), .rx_irq(rx_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        byte_vld = 1'b1;
        byte_in  = b;
        step();
        byte_vld = 1'b0;
    endtask

    task automatic pop_exp(input string tag, input logic [7:0] exp);
        chk(tag, rd_data, exp);
        rd_pop = 1'b1;
        step();
        rd_pop = 1'b0;
    endtask

    task automatic drain();
        while (level != 0) begin
            rd_pop = 1'b1;
            step();
            rd_pop = 1'b0;
        end
    endtask

    task automatic ticks(input int n);
        char_tick = 1'b1;
        repeat (n) step();
        char_tick = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 level", level, 0);
        chk("R1 data_full", data_full, 0);
        chk("R1 rx_irq", rx_irq, 0);
        chk("R1 rd_data", rd_data, 0);
    endtask

    task automatic t_order();
        trig_sel = 2'd3;
        for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
        chk("R2 level after 5", level, 5);
        for (int i = 0; i < 5; i++) pop_exp("R2 order", 8'hA0 + 8'(i));
        chk("R8 level after pops", level, 0);
    endtask

    task automatic t_wrap();
        trig_sel = 2'd3;
        for (int i = 0; i < 16; i++) push(8'h40 + 8'(i));
        chk("R3 level full", level, 16);
        chk("R5 flag at 14+", data_full, 1);
        push(8'hEE);
        chk("R3 level after drop", level, 16);
        for (int i = 0; i < 16; i++) pop_exp("R2 R3 wrap order", 8'h40 + 8'(i));
        chk("R8 flag cleared", data_full, 0);
    endtask

    task automatic t_rxen();
        rx_en = 1'b0;
        push(8'h11);
        chk("R4 level", level, 0);
        chk("R4 rd_data", rd_data, 0);
        rx_en = 1'b1;
    endtask

    task automatic t_empty();
        chk("R9 rd_data empty", rd_data, 0);
        rd_pop = 1'b1;
        step();
        rd_pop = 1'b0;
        chk("R9 level", level, 0);
        chk("R9 flag", data_full, 0);
        chk("R9 rd_data after", rd_data, 0);
    endtask

    task automatic t_trig();
        int lv[4] = '{1, 4, 8, 14};
        rie = 1'b1;
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            for (int i = 0; i < lv[s] - 1; i++) push(8'(i));
            chk("R5 below trigger", data_full, 0);
            chk("R6 no irq below", rx_irq, 0);
            push(8'h77);
            chk("R5 at trigger", data_full, 1);
            chk("R6 irq at trigger", rx_irq, 1);
            rie = 1'b0;
            step();
            chk("R6 irq withdrawn", rx_irq, 0);
            rie = 1'b1;
            rd_pop = 1'b1;
            step();
            rd_pop = 1'b0;
            chk("R8 flag clears", data_full, 0);
            chk("R8 level dec", level, lv[s] - 1);
            drain();
        end
        rie = 1'b0;
    endtask

    task automatic t_timeout();
        trig_sel = 2'd2;
        rie = 1'b1;
        for (int i = 0; i < 3; i++) push(8'h30 + 8'(i));
        ticks(14);
        chk("R7 not yet", data_full, 0);
        ticks(1);
        chk("R7 flag on timeout", data_full, 1);
        chk("R7 irq on timeout", rx_irq, 1);
        chk("R7 level kept", level, 3);
        rie = 1'b0;
        step();
        drain();
        chk("R8 flag cleared", data_full, 0);
        push(8'h01);
        ticks(10);
        push(8'h02);
        ticks(10);
        chk("R7 restart", data_full, 0);
        ticks(5);
        chk("R7 restarted expiry", data_full, 1);
        chk("R6 no irq when disabled", rx_irq, 0);
        drain();
    endtask

    task automatic t_cancel();
        trig_sel = 2'd1;
        rie = 1'b1;
        for (int i = 0; i < 4; i++) push(8'h50 + 8'(i));
        chk("R12 flag", data_full, 1);
        pop_exp("R12 pop", 8'h50);
        chk("R12 flag cleared", data_full, 0);
        ticks(20);
        chk("R12 timer stopped", data_full, 0);
        rie = 1'b0;
        step();
        chk("R6 irq off", rx_irq, 0);
        drain();
    endtask

    task automatic t_same();
        trig_sel = 2'd3;
        push(8'hC1);
        push(8'hC2);
        chk("R11 head", rd_data, 8'hC1);
        byte_vld = 1'b1;
        byte_in  = 8'hC3;
        rd_pop   = 1'b1;
        step();
        byte_vld = 1'b0;
        rd_pop   = 1'b0;
        chk("R11 level", level, 2);
        pop_exp("R11 order", 8'hC2);
        pop_exp("R11 order", 8'hC3);
        chk("R11 empty", level, 0);
    endtask

    task automatic t_clr();
        trig_sel = 2'd3;
        for (int i = 0; i < 3; i++) push(8'h90 + 8'(i));
        byte_vld = 1'b1;
        byte_in  = 8'h99;
        fifo_clr = 1'b1;
        step();
        byte_vld = 1'b0;
        fifo_clr = 1'b0;
        chk("R10 level", level, 0);
        chk("R10 rd_data", rd_data, 0);
        push(8'h5A);
        chk("R10 next byte", rd_data, 8'h5A);
        chk("R10 level 1", level, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        step();
        t_reset();
        t_order();
        t_wrap();
        t_rxen();
        t_empty();
        t_trig();
        t_timeout();
        t_cancel();
        t_same();
        t_clr();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule